// File: doc/BRIEF.md
# Opcode-Snooping Fast Output Port

This block sits beside a small 8-bit processor and turns single-cycle NOP opcodes into writes to a narrow output port. The processor marks each opcode fetch with a sync strobe. When the fetched byte has binary 011 in its three low bits, the block takes the byte's upper bits as the new port value. The processor still executes the byte as a one-cycle NOP. Software therefore writes a constant to the port at the cost of a single fetch cycle. No address space is used and no store cycle is needed.

Two options shape the decode. A mode select narrows the port to four bits by accepting only bytes whose bit 3 is clear. An exclusion enable refuses the two byte values 0xCB and 0xDB, because some processor variants execute these as real instructions. The port value is registered. A one-clock pulse flags each accepted write.

Top module: `opsnoop_port`

## Requirements
- R1: A byte is accepted only when its bits 2..0 equal binary 011. Bytes with any other low pattern leave `port_o` unchanged and give `upd_o` low in the following cycle.
- R2: With `nib_mode_i` = 0 (wide mode), an accepted byte puts its bits 7..3 on `port_o` in the clock cycle after the fetch.
- R3: Accepted bytes on consecutive cycles are each captured with no dead cycle. During a run of any length, `port_o` follows each byte one cycle later and `upd_o` stays high.
- R4: A byte presented while `sync_i` is low never changes `port_o` and never raises `upd_o`, even when it matches the pattern.
- R5: With `excl_en_i` = 1, the bytes 0xCB and 0xDB are refused and all other matching bytes are still accepted. With `excl_en_i` = 0, both of these bytes are accepted like any other matching byte.
- R6: With `nib_mode_i` = 1 (narrow mode), a byte is accepted only if bits 3..0 equal 0011. On acceptance `port_o` becomes {0, bits 7..4}. Bytes with bit 3 set are ignored.
- R7: After a write, `port_o` holds its value through any number of refused or non-fetch cycles until the next accepted byte.
- R8: A synchronous active-high `rst_i` drives `port_o` to 0 and `upd_o` to 0 in the next cycle. Reset takes priority over a byte accepted in the same cycle.
- R9: `upd_o` is high for exactly the one cycle that follows each accepted byte and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | High during an opcode-fetch bus cycle |
| data_i | input | 8 | Processor data bus |
| nib_mode_i | input | 1 | 0 = 5-bit port, 1 = 4-bit port |
| excl_en_i | input | 1 | 1 = refuse 0xCB and 0xDB |
| port_o | output | 5 | Registered port value |
| upd_o | output | 1 | One-cycle pulse after each accepted write |

## Verification
Each output is registered once, so every result is due exactly one clock after the fetch cycle that caused it. The bench changes inputs on the falling edge and samples the outputs on the next falling edge. That sample point falls after the single rising edge that registers the result, and before the inputs change again. Reset is checked the same way, one cycle after it is applied. Hold and refusal cases are judged against the value written most recently, which the bench tracks itself.

// File: rtl/opsnoop_pkg.sv
package opsnoop_pkg;
    parameter int unsigned OP_W   = 8;
    parameter int unsigned TAG_W  = 3;
    parameter int unsigned PORT_W = OP_W - TAG_W;
    parameter logic [TAG_W-1:0] TAG_VAL = 3'b011;
    parameter int unsigned N_EXCL = 2;
    parameter logic [OP_W-1:0] EXCL_CODES [N_EXCL] = '{8'hCB, 8'hDB};

    typedef enum logic {
        PORT_WIDE   = 1'b0,
        PORT_NARROW = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] val;
        logic              upd;
    } hold_st_t;
endpackage

// File: rtl/opsnoop_match.sv
module opsnoop_match
    import opsnoop_pkg::*;
(
    input  logic              sync_i,
    input  logic [OP_W-1:0]   op_i,
    input  port_mode_e        mode_i,
    input  logic              excl_en_i,
    output logic              hit_o,
    output logic [PORT_W-1:0] val_o
);
    localparam int unsigned NARROW_W = PORT_W - 1;

    logic [N_EXCL-1:0] code_eq;
    logic              tag_ok;
    logic              excluded;

    for (genvar gi = 0; gi < N_EXCL; gi++) begin : g_excl
        assign code_eq[gi] = (op_i == EXCL_CODES[gi]);
    end

    assign tag_ok   = (op_i[TAG_W-1:0] == TAG_VAL);
    assign excluded = excl_en_i && (|code_eq);

    always_comb begin
        hit_o = 1'b0;
        val_o = '0;
        if (sync_i && tag_ok) begin
            if (mode_i == PORT_NARROW) begin
                hit_o = !op_i[TAG_W];
                val_o = {1'b0, op_i[OP_W-1 -: NARROW_W]};
            end else begin
                hit_o = !excluded;
                val_o = op_i[OP_W-1 -: PORT_W];
            end
        end
    end
endmodule

// File: rtl/opsnoop_hold.sv
module opsnoop_hold
    import opsnoop_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              take_i,
    input  logic [PORT_W-1:0] val_i,
    output logic [PORT_W-1:0] port_o,
    output logic              upd_o
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = take_i;
        if (take_i) begin
            st_d.val = val_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_o = st_q.val;
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/opsnoop_port.sv
module opsnoop_port
    import opsnoop_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sync_i,
    input  logic [OP_W-1:0]   data_i,
    input  logic              nib_mode_i,
    input  logic              excl_en_i,
    output logic [PORT_W-1:0] port_o,
    output logic              upd_o
);
    logic              hit;
    logic [PORT_W-1:0] hit_val;
    port_mode_e        mode;

    assign mode = port_mode_e'(nib_mode_i);

    opsnoop_match u_match (
        .sync_i    (sync_i),
        .op_i      (data_i),
        .mode_i    (mode),
        .excl_en_i (excl_en_i),
        .hit_o     (hit),
        .val_o     (hit_val)
    );

    opsnoop_hold u_hold (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .take_i (hit),
        .val_i  (hit_val),
        .port_o (port_o),
        .upd_o  (upd_o)
    );
endmodule

// File: rtl/opsnoop_port_chk.sv
module opsnoop_port_chk
    import opsnoop_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              sync_i,
    input logic [OP_W-1:0]   data_i,
    input logic              nib_mode_i,
    input logic              excl_en_i,
    input logic [PORT_W-1:0] port_o,
    input logic              upd_o
);
    logic live_q = 1'b0;
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk_i) begin
        rst_seen_q <= rst_i;
        live_q     <= !rst_i;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_seen_q |-> (port_o == '0 && !upd_o)); // R8

    AST_NO_FETCH_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && !$past(sync_i)) |-> (!upd_o && $stable(port_o))); // R4

    AST_WIDE_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $past(sync_i) && !$past(nib_mode_i) && !$past(excl_en_i)
         && $past(data_i[TAG_W-1:0]) == TAG_VAL)
        |-> (upd_o && port_o == $past(data_i[OP_W-1 -: PORT_W]))); // R2

    AST_NARROW_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $past(sync_i) && $past(nib_mode_i)
         && $past(data_i[TAG_W:0]) == {1'b0, TAG_VAL})
        |-> (upd_o && port_o == {1'b0, $past(data_i[OP_W-1 -: PORT_W-1])})); // R6

    AST_EXCL_REFUSED: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $past(excl_en_i)
         && ($past(data_i) == 8'hCB || $past(data_i) == 8'hDB))
        |-> (!upd_o && $stable(port_o))); // R5

    AST_HOLD_WITHOUT_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && !upd_o) |-> $stable(port_o)); // R7
endmodule

bind opsnoop_port opsnoop_port_chk u_chk (.*);

// File: tb/tb_opsnoop_port.sv
module tb_opsnoop_port;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       sync_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       nib_mode_i = 1'b0;
    logic       excl_en_i = 1'b0;
    logic [4:0] port_o;
    logic       upd_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk_i = ~clk_i;

    opsnoop_port dut (.*);

    // {sync, nib, excl, data[7:0], exp_port[4:0], exp_upd}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'hFB, 5'h1F, 1'b1}, // R2
        {1'b1, 1'b0, 1'b0, 8'h13, 5'h02, 1'b1}, // R3
        {1'b1, 1'b0, 1'b0, 8'hA9, 5'h02, 1'b0}, // R1
        {1'b0, 1'b0, 1'b0, 8'h7B, 5'h02, 1'b0}, // R4
        {1'b1, 1'b0, 1'b1, 8'hCB, 5'h02, 1'b0}, // R5
        {1'b1, 1'b0, 1'b1, 8'hDB, 5'h02, 1'b0}, // R5
        {1'b1, 1'b0, 1'b1, 8'hEB, 5'h1D, 1'b1}, // R5
        {1'b1, 1'b0, 1'b0, 8'hCB, 5'h19, 1'b1}, // R5
        {1'b1, 1'b1, 1'b0, 8'h5B, 5'h19, 1'b0}, // R6
        {1'b1, 1'b1, 1'b0, 8'hF3, 5'h0F, 1'b1}, // R6
        {1'b1, 1'b1, 1'b0, 8'h63, 5'h06, 1'b1}, // R6
        {1'b1, 1'b0, 1'b0, 8'h45, 5'h06, 1'b0}, // R7
        {1'b0, 1'b0, 1'b0, 8'h00, 5'h06, 1'b0}, // R9
        {1'b1, 1'b0, 1'b0, 8'h03, 5'h00, 1'b1}  // R2
    };

    task automatic check(input string req, input logic [4:0] ep, input logic eu);
        n_vec++;
        if (port_o !== ep || upd_o !== eu) begin
            n_bad++;
            $display("FAIL %s: port=%h upd=%b expected port=%h upd=%b",
                     req, port_o, upd_o, ep, eu);
        end
    endtask

    task automatic drive(input logic s, input logic n, input logic e, input logic [7:0] d);
        sync_i = s; nib_mode_i = n; excl_en_i = e; data_i = d;
        @(negedge clk_i);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: port=%h upd=%b expected run to end", port_o, upd_o);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        @(negedge clk_i);
        check("R8", 5'h00, 1'b0);
        rst_i = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:6]);
            check($sformatf("R1-table vector %0d", i), VEC[i][5:1], VEC[i][0]);
        end

        // long back-to-back run, each value captured
        for (int k = 0; k < 40; k++) begin
            logic [4:0] v;
            v = 5'(k * 7 + 3);
            drive(1'b1, 1'b0, 1'b0, {v, 3'b011});
            check("R3", v, 1'b1);
        end
        drive(1'b0, 1'b0, 1'b0, 8'h3B);
        check("R9", 5'(39 * 7 + 3), 1'b0);

        // reset beats a simultaneous accepted byte
        drive(1'b1, 1'b0, 1'b0, 8'hB3);
        check("R2", 5'h16, 1'b1);
        rst_i = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 8'hFB);
        check("R8", 5'h00, 1'b0);
        rst_i = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 8'hFB);
        check("R7", 5'h00, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule